// File: doc/BRIEF.md
# Cascadable DMA Channel Prioritizer

This block decides which of four local DMA channels, or a fifth request arriving from a downstream controller in a cascade, is served next. Each source sits in one of five priority slots. Software sets the slot order and a per-source mask through a single write port. A global enable input gates the whole arbitration.

While any unmasked source is pending and the enable is high, the block pulls an active-low request toward the system bus arbiter. When the bus grant arrives, and the upstream grant-enable of the daisy chain is also active, the block latches the highest-priority pending source. It then presents that source as a one-hot winner until the transfer is reported finished. If the cascade slot wins, the block passes the grant on to the downstream controller through its own grant-enable output. Several controllers can be chained this way to serve more channels.

Top module: `dma_casc_prio`

## Requirements
- R1: After reset the priority order is channel 0, 1, 2, 3, cascade (highest first), and every source is masked. With all requests high and the grant active, `req_out_n` stays high and `win_onehot` stays zero.
- R2: `req_out_n` is low in the same cycle that at least one unmasked request is high while `arb_en` is high. Otherwise it is high. `req_casc` counts as a request.
- R3: A masked source (mask bit 1 at its code position) neither pulls `req_out_n` low nor can become the winner.
- R4: While `arb_en` is low, `req_out_n` is high and no new winner is latched.
- R5: The winner is the pending unmasked source whose code sits in the lowest slot of the order. Slot 0 is the highest. Codes 0 to 3 name channels 0 to 3, code 4 names the cascade input, and `win_onehot` bit i stands for code i.
- R6: A configuration write whose five 3-bit slot codes are not a permutation of {0,1,2,3,4} is dropped whole. Both the previous order and the previous mask stay in force.
- R7: The winner is latched at the first clock edge at which the block is idle, both `bus_grant_n` and `chain_en_in_n` are low, and an unmasked enabled request is pending. It appears on `win_onehot` from the following cycle. It stays unchanged, without pre-emption, until the edge at which `xfer_done` is high, after which `win_onehot` is zero.
- R8: `chain_en_out_n` is low exactly while a cascade win is held and both `bus_grant_n` and `chain_en_in_n` are low.
- R9: `win_onehot` never has more than one bit set.
- R10: A valid configuration write is sampled at the clock edge and governs requests and arbitration from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_ch | input | 4 | Local channel requests, active high, bit i = channel i |
| req_casc | input | 1 | Request from the downstream controller, active high |
| arb_en | input | 1 | Global arbitration enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_order | input | 15 | Five 3-bit slot codes, bits [2:0] = slot 0 (highest) |
| cfg_mask | input | 5 | Per-code mask, 1 = masked, bit 4 = cascade |
| bus_grant_n | input | 1 | Bus grant from the system arbiter, active low |
| chain_en_in_n | input | 1 | Grant-enable from upstream, active low |
| xfer_done | input | 1 | Ends the transfer in progress |
| req_out_n | output | 1 | Bus request toward the system arbiter, active low |
| win_onehot | output | 5 | Latched winner, one-hot by code |
| chain_en_out_n | output | 1 | Grant-enable toward downstream, active low |

## Verification
`req_out_n` and `chain_en_out_n` are combinational from inputs and registered state. Each is therefore checked one nanosecond after the inputs change on the falling edge, within the same cycle. A configuration write and a winner latch both take effect over one rising edge. The bench drives them on a falling edge and compares `win_onehot` and the affected request on the next falling edge, never earlier. Scenarios that must not latch are held for at least two edges before comparison.

// File: rtl/dprio_pkg.sv
// Package: shared sizing for the cascadable DMA prioritizer.
// Assumes one cascade slot placed after the local channels in code space.
package dprio_pkg;
    parameter int unsigned DP_NUM_CH = 4;
    localparam int unsigned DP_NUM_SLOT = DP_NUM_CH + 1;
    localparam int unsigned DP_CODE_W   = $clog2(DP_NUM_SLOT);
endpackage

// File: rtl/dprio_cfg.sv
// Module: holds the priority order and mask.
// A write is taken only if the slot codes form a permutation of all sources.
// Assumes cfg inputs are stable around the clock edge when wr_en is high.
module dprio_cfg #(
    parameter int unsigned NUM_CH = dprio_pkg::DP_NUM_CH
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [(NUM_CH+1)*$clog2(NUM_CH+1)-1:0] wr_order,
    input  logic [NUM_CH:0]              wr_mask,
    output logic [(NUM_CH+1)*$clog2(NUM_CH+1)-1:0] order_q,
    output logic [NUM_CH:0]              mask_q
);
    localparam int unsigned NS = NUM_CH + 1;
    localparam int unsigned CW = $clog2(NS);

    logic [NS*CW-1:0] rst_order;
    logic [NS-1:0]    seen;
    logic             wr_valid;

    // Default order: slot s holds code s (channels first, cascade last).
    for (genvar g = 0; g < NS; g++) begin : g_rst_order
        assign rst_order[g*CW +: CW] = CW'(g);
    end

    // Mark each source code that appears in some slot of the incoming order.
    always_comb begin
        seen = '0;
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < NS; c++) begin
                if (wr_order[s*CW +: CW] == CW'(c)) seen[c] = 1'b1;
            end
        end
    end

    assign wr_valid = &seen;

    // Configuration registers: reset to default order and all masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order_q <= rst_order;
            mask_q  <= '1;
        end else if (wr_en && wr_valid) begin
            order_q <= wr_order;
            mask_q  <= wr_mask;
        end
    end

    AST_BAD_WRITE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_valid) |=> ($stable(order_q) && $stable(mask_q))); // R6
    AST_GOOD_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid) |=> (order_q == $past(wr_order))); // R10
endmodule

// File: rtl/dprio_pick.sv
// Module: combinational priority pick over a programmable slot order.
// Assumes order is a permutation; returns the first pending code by slot.
module dprio_pick #(
    parameter int unsigned NUM_CH = dprio_pkg::DP_NUM_CH
) (
    input  logic [NUM_CH:0]              pend,
    input  logic [(NUM_CH+1)*$clog2(NUM_CH+1)-1:0] order,
    output logic [NUM_CH:0]              pick,
    output logic                         any
);
    localparam int unsigned NS = NUM_CH + 1;
    localparam int unsigned CW = $clog2(NS);

    logic found;

    // Walk slots from highest to lowest priority; first pending code wins.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int s = 0; s < NS; s++) begin
            for (int c = 0; c < NS; c++) begin
                if (!found && order[s*CW +: CW] == CW'(c) && pend[c]) begin
                    pick[c] = 1'b1;
                    found   = 1'b1;
                end
            end
        end
    end

    assign any = |pend;
endmodule

// File: rtl/dma_casc_prio.sv
// Module: top of the cascadable DMA prioritizer.
// Gates requests by mask and enable, raises the bus request, latches the
// winner under grant and holds it until xfer_done, and forwards the grant
// down the chain when the cascade slot wins.
// Assumes xfer_done is asserted only while a winner is held.
module dma_casc_prio #(
    parameter int unsigned NUM_CH = dprio_pkg::DP_NUM_CH,
    localparam int unsigned NS = NUM_CH + 1,
    localparam int unsigned CW = $clog2(NS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUM_CH-1:0] req_ch,
    input  logic            req_casc,
    input  logic            arb_en,
    input  logic            cfg_we,
    input  logic [NS*CW-1:0] cfg_order,
    input  logic [NS-1:0]   cfg_mask,
    input  logic            bus_grant_n,
    input  logic            chain_en_in_n,
    input  logic            xfer_done,
    output logic            req_out_n,
    output logic [NS-1:0]   win_onehot,
    output logic            chain_en_out_n
);
    localparam int unsigned CASC = NUM_CH;

    logic [NS*CW-1:0] order_q;
    logic [NS-1:0]    mask_q;
    logic [NS-1:0]    live;
    logic [NS-1:0]    pick;
    logic             any_live;
    logic             granted;
    logic             busy_q;
    logic [NS-1:0]    win_q;

    dprio_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_order (cfg_order),
        .wr_mask  (cfg_mask),
        .order_q  (order_q),
        .mask_q   (mask_q)
    );

    // Unmasked requests, all suppressed while arbitration is disabled.
    assign live = {req_casc, req_ch} & ~mask_q & {NS{arb_en}};

    dprio_pick #(.NUM_CH(NUM_CH)) u_pick (
        .pend  (live),
        .order (order_q),
        .pick  (pick),
        .any   (any_live)
    );

    assign granted = !bus_grant_n && !chain_en_in_n;

    // Winner register: latch on grant when idle, release on xfer_done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            win_q  <= '0;
        end else if (busy_q) begin
            if (xfer_done) begin
                busy_q <= 1'b0;
                win_q  <= '0;
            end
        end else if (granted && any_live) begin
            busy_q <= 1'b1;
            win_q  <= pick;
        end
    end

    assign req_out_n      = !any_live;
    assign win_onehot     = win_q;
    assign chain_en_out_n = !(busy_q && win_q[CASC] && granted);

    AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_onehot)); // R9
    AST_HOLD_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !xfer_done) |=> $stable(win_onehot)); // R7
    AST_NO_GRANT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && (bus_grant_n || chain_en_in_n)) |=> (win_onehot == '0)); // R7
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !arb_en) |=> (win_onehot == '0)); // R4
    AST_WIN_WAS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ((win_onehot & $past(live)) != '0)); // R3
    AST_CHAIN_ONLY_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_en_out_n |-> (win_onehot[CASC] && !chain_en_in_n)); // R8
endmodule

// File: tb/test_dma_casc_prio.sv
// Bench: scoreboard with a driver that queues expected outputs and a
// monitor that pops and compares them against the design's ports.
module test_dma_casc_prio;
    localparam time CLK_P = 10ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req_ch;
    logic        req_casc;
    logic        arb_en;
    logic        cfg_we;
    logic [14:0] cfg_order;
    logic [4:0]  cfg_mask;
    logic        bus_grant_n;
    logic        chain_en_in_n;
    logic        xfer_done;
    logic        req_out_n;
    logic [4:0]  win_onehot;
    logic        chain_en_out_n;

    typedef struct {
        string      rid;
        logic [4:0] win;
        logic       reqn;
        logic       chn;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_casc_prio i_dma_casc_prio (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_ch         (req_ch),
        .req_casc       (req_casc),
        .arb_en         (arb_en),
        .cfg_we         (cfg_we),
        .cfg_order      (cfg_order),
        .cfg_mask       (cfg_mask),
        .bus_grant_n    (bus_grant_n),
        .chain_en_in_n  (chain_en_in_n),
        .xfer_done      (xfer_done),
        .req_out_n      (req_out_n),
        .win_onehot     (win_onehot),
        .chain_en_out_n (chain_en_out_n)
    );

    function automatic logic [14:0] ord(input logic [2:0] s0, s1, s2, s3, s4);
        return {s4, s3, s2, s1, s0};
    endfunction

    // Monitor: compare every queued expectation against the ports.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (win_onehot !== e.win || req_out_n !== e.reqn || chain_en_out_n !== e.chn) begin
                    n_bad++;
                    $display("FAIL %s: win=%b reqn=%b chn=%b, expected win=%b reqn=%b chn=%b",
                             e.rid, win_onehot, req_out_n, chain_en_out_n, e.win, e.reqn, e.chn);
                end
                n_vec++;
                if (!$onehot0(win_onehot)) begin
                    n_bad++;
                    $display("FAIL R9: win=%b, expected at most one bit", win_onehot);
                end
            end
        end
    end

    // Driver side: queue an expectation and hand it to the monitor.
    task automatic expect_out(input string rid, input logic [4:0] w, input logic rn, input logic cn);
        exp_t e;
        e.rid = rid; e.win = w; e.reqn = rn; e.chn = cn;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic wr_cfg(input logic [14:0] o, input logic [4:0] m);
        cfg_we = 1'b1; cfg_order = o; cfg_mask = m;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic finish_xfer();
        xfer_done = 1'b1; bus_grant_n = 1'b1;
        cyc();
        xfer_done = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_ch = 4'hF; req_casc = 1'b1; arb_en = 1'b1;
        cfg_we = 1'b0; cfg_order = '0; cfg_mask = '0;
        bus_grant_n = 1'b0; chain_en_in_n = 1'b0; xfer_done = 1'b0;
        @(negedge clk);
        cyc(); cyc(); cyc();
        settle();
        expect_out("R1 in reset", 5'b00000, 1'b1, 1'b1);
        rst_n = 1'b1;
        cyc(); cyc();
        settle();
        expect_out("R1 all masked after reset", 5'b00000, 1'b1, 1'b1);

        // Unmask all with default order; takes effect after the edge.
        bus_grant_n = 1'b1;
        cfg_we = 1'b1; cfg_order = ord(0, 1, 2, 3, 4); cfg_mask = 5'b00000;
        settle();
        expect_out("R10 write not yet applied", 5'b00000, 1'b1, 1'b1);
        cyc();
        cfg_we = 1'b0;
        settle();
        expect_out("R10 R2 write applied", 5'b00000, 1'b0, 1'b1);

        bus_grant_n = 1'b0;
        cyc();
        settle();
        expect_out("R5 R1 default order picks ch0", 5'b00001, 1'b0, 1'b1);

        // Raise cascade to top while busy: no pre-emption.
        wr_cfg(ord(4, 3, 2, 1, 0), 5'b00000);
        cyc();
        settle();
        expect_out("R7 held without pre-emption", 5'b00001, 1'b0, 1'b1);
        finish_xfer();
        settle();
        expect_out("R7 released after xfer_done", 5'b00000, 1'b0, 1'b1);

        bus_grant_n = 1'b0;
        cyc();
        settle();
        expect_out("R8 R5 cascade wins and passes grant", 5'b10000, 1'b0, 1'b0);
        bus_grant_n = 1'b1;
        settle();
        expect_out("R8 grant withdrawn", 5'b10000, 1'b0, 1'b1);
        finish_xfer();

        // Mask the cascade slot.
        wr_cfg(ord(4, 3, 2, 1, 0), 5'b10000);
        req_ch = 4'b0110; req_casc = 1'b1;
        settle();
        expect_out("R2 unmasked channels request", 5'b00000, 1'b0, 1'b1);
        bus_grant_n = 1'b0;
        cyc();
        settle();
        expect_out("R3 R5 masked cascade skipped, ch2 wins", 5'b00100, 1'b0, 1'b1);
        finish_xfer();
        req_ch = 4'b0000;
        settle();
        expect_out("R3 masked cascade alone gives no request", 5'b00000, 1'b1, 1'b1);

        // Rejected writes: duplicate code, then out-of-range code.
        wr_cfg(ord(0, 0, 1, 2, 3), 5'b00000);
        settle();
        expect_out("R6 duplicate order dropped, mask kept", 5'b00000, 1'b1, 1'b1);
        wr_cfg(ord(7, 3, 2, 1, 0), 5'b00000);
        settle();
        expect_out("R6 bad code dropped, mask kept", 5'b00000, 1'b1, 1'b1);
        req_ch = 4'b0110;
        bus_grant_n = 1'b0;
        cyc();
        settle();
        expect_out("R6 previous order kept", 5'b00100, 1'b0, 1'b1);
        finish_xfer();

        // New valid order 1,2,3,0,C.
        wr_cfg(ord(1, 2, 3, 0, 4), 5'b00000);
        req_ch = 4'b1111; req_casc = 1'b1; bus_grant_n = 1'b0;
        cyc();
        settle();
        expect_out("R5 order 1,2,3,0,C picks ch1", 5'b00010, 1'b0, 1'b1);
        finish_xfer();
        req_ch = 4'b1001; bus_grant_n = 1'b0;
        cyc();
        settle();
        expect_out("R5 order 1,2,3,0,C picks ch3", 5'b01000, 1'b0, 1'b1);
        finish_xfer();

        // Disabled arbitration.
        req_ch = 4'b1111; arb_en = 1'b0; bus_grant_n = 1'b0;
        settle();
        expect_out("R4 disabled gives no request", 5'b00000, 1'b1, 1'b1);
        cyc(); cyc();
        settle();
        expect_out("R4 disabled latches nothing", 5'b00000, 1'b1, 1'b1);
        arb_en = 1'b1;

        // Upstream chain not passing the grant.
        chain_en_in_n = 1'b1;
        cyc(); cyc();
        settle();
        expect_out("R7 no latch without chain enable", 5'b00000, 1'b0, 1'b1);
        chain_en_in_n = 1'b0;
        cyc();
        settle();
        expect_out("R7 latch once chain enable arrives", 5'b00010, 1'b0, 1'b1);
        finish_xfer();
        settle();
        expect_out("R7 idle after end", 5'b00000, 1'b0, 1'b1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule